// File: doc/BRIEF.md
# Set/Clear Register GPIO Controller

This block is a memory-mapped general purpose I/O controller with three regular bidirectional ports of 8, 24 and 13 pins. It also has a mixed fourth group (port 3) made of 6 bidirectional pins, 23 input-only pins and 24 output-only pins. Software never writes an output level or a direction directly. Each bit is changed through a set register, where a one forces the bit high, or a clear register, where a one forces it low. Zero bits in either write leave the state alone, so two agents can touch different pins without a read-modify-write race.

The bus side is a single-cycle register port: a byte address, a write strobe, 32-bit write data and a combinational 32-bit read data. On the pin side, each port has an output latch vector, an output-enable vector (the direction) and an input vector. Every input passes through a two-flop synchronizer before software can read it. The port 3 pins sit at irregular bit positions. Their directions live in the upper bits of port 2's direction registers, and their input bits are scattered around the input-only field.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: After reset, every output-enable is 0, every output latch is 0, and every direction and output-state readback register reads 0.
- R2: Writing to a direction set register makes each pin whose bit is 1 an output (oe=1). Writing to the matching clear register makes each such pin an input (oe=0). The set and clear offsets are 0x050/0x054 for port 0, 0x070/0x074 for port 1, and bits 0..12 of 0x010/0x014 for port 2. The direction state reads back at 0x058, 0x078 and 0x018 (bits 0..12).
- R3: In every set or clear write, zero bits leave the matching state bit unchanged. One bits force it to 1 (set) or to 0 (clear).
- R4: Output latches are changed through 0x044/0x048 (port 0), 0x064/0x068 (port 1) and 0x020/0x024 (port 2). Ports 0 and 1 read their latches back at 0x04C and 0x06C. Each latch value appears on its output pin whatever the pin's direction.
- R5: The direction of port 3 bidirectional pin j (0..5) is set or cleared by bit 25+j of 0x010/0x014. It reads back at bit 25+j of 0x018.
- R6: Writes to 0x004/0x008 change port 3 output latches. Bits 0..23 drive output-only pins 0..23, and bits 25..30 drive bidirectional pins 0..5. 0x00C reads both groups back at those same bit positions, and its other bits read 0.
- R7: Input state reads as follows. For ports 0, 1 and 2, pin n reads at bit n of 0x040, 0x060 and 0x01C. In 0x000, bidirectional pins 0..4 read at bits 10..14 and bidirectional pin 5 at bit 24. Input-only pins 0..9 read at bits 0..9, pins 10..18 at bits 15..23, and pins 19..22 at bits 25..28. Bits 29..31 read 0.
- R8: A pin input change becomes visible in its input state register after exactly two rising clock edges, and not after one.
- R9: Reads of any offset other than the ten state registers return 0, including the set and clear offsets. Writes to unmapped or read-only offsets, and cycles with the write strobe low, change no pin and no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| p0_in | input | 8 | Port 0 pad inputs |
| p0_out | output | 8 | Port 0 output latches |
| p0_oe | output | 8 | Port 0 output enables |
| p1_in | input | 24 | Port 1 pad inputs |
| p1_out | output | 24 | Port 1 output latches |
| p1_oe | output | 24 | Port 1 output enables |
| p2_in | input | 13 | Port 2 pad inputs |
| p2_out | output | 13 | Port 2 output latches |
| p2_oe | output | 13 | Port 2 output enables |
| p3io_in | input | 6 | Port 3 bidirectional pad inputs |
| p3io_out | output | 6 | Port 3 bidirectional output latches |
| p3io_oe | output | 6 | Port 3 bidirectional output enables |
| p3i_in | input | 23 | Port 3 input-only pads |
| p3o_out | output | 24 | Port 3 output-only latches |

## Verification
The bench targets the bit placement of port 3. It drives single bidirectional pin 5 and input-only pins 10 and 19, the points where the input word jumps, so that an off-by-one packing would show up as a bit in the wrong position or in the bit 24 slot. It also checks that the port 3 direction bits written through port 2's set/clear offsets land on p3io_oe and not on p2_oe, a confusion that would move the wrong pads. Overlapping set-then-clear patterns expose a design that writes the full word instead of applying only the ones. A pin toggle sampled after one and after two edges catches a synchronizer that is one stage short or one stage long. Writes of all ones to unmapped and read-only offsets catch address decode that aliases onto a live register.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int DW      = 32;
  localparam int AW      = 8;
  localparam int P0W     = 8;
  localparam int P1W     = 24;
  localparam int P2W     = 13;
  localparam int P3BW    = 6;
  localparam int P3IW    = 23;
  localparam int P3OW    = 24;
  localparam int P3B_LSB = 25;   // port 3 bidir field in set/clear/dir words
  localparam int P3B_RDLO = 10;  // bidir pins 0..4 in the input word
  localparam int P3B_RDHI = 24;  // last bidir pin in the input word

  // port 3 / port 2 shared map
  localparam logic [AW-1:0] A_P3_IN   = 8'h00;
  localparam logic [AW-1:0] A_P3_OSET = 8'h04;
  localparam logic [AW-1:0] A_P3_OCLR = 8'h08;
  localparam logic [AW-1:0] A_P3_OST  = 8'h0C;
  localparam logic [AW-1:0] A_D2_SET  = 8'h10;
  localparam logic [AW-1:0] A_D2_CLR  = 8'h14;
  localparam logic [AW-1:0] A_D2_ST   = 8'h18;
  localparam logic [AW-1:0] A_P2_IN   = 8'h1C;
  localparam logic [AW-1:0] A_P2_OSET = 8'h20;
  localparam logic [AW-1:0] A_P2_OCLR = 8'h24;

  // regular ports: base plus a fixed layout
  localparam logic [AW-1:0] A_P0_BASE = 8'h40;
  localparam logic [AW-1:0] A_P1_BASE = 8'h60;
  localparam logic [AW-1:0] R_IN   = 8'h00;
  localparam logic [AW-1:0] R_OSET = 8'h04;
  localparam logic [AW-1:0] R_OCLR = 8'h08;
  localparam logic [AW-1:0] R_OST  = 8'h0C;
  localparam logic [AW-1:0] R_DSET = 8'h10;
  localparam logic [AW-1:0] R_DCLR = 8'h14;
  localparam logic [AW-1:0] R_DST  = 8'h18;

  // bit position of input-only pin k in the port 3 input word
  function automatic int unsigned p3i_pos(input int unsigned k);
    if (k < 10)      return k;
    else if (k < 19) return k + 5;
    else             return k + 6;
  endfunction

  function automatic logic [DW-1:0] p3_in_word(input logic [P3BW-1:0] b,
                                               input logic [P3IW-1:0] g);
    logic [DW-1:0] w;
    w = '0;
    for (int unsigned k = 0; k < P3IW; k++) w[p3i_pos(k)] = g[k];
    for (int j = 0; j < P3BW - 1; j++) w[P3B_RDLO + j] = b[j];
    w[P3B_RDHI] = b[P3BW-1];
    return w;
  endfunction

  function automatic logic is_readable(input logic [AW-1:0] a);
    return a inside {A_P3_IN, A_P3_OST, A_D2_ST, A_P2_IN,
                     A_P0_BASE + R_IN, A_P0_BASE + R_OST, A_P0_BASE + R_DST,
                     A_P1_BASE + R_IN, A_P1_BASE + R_OST, A_P1_BASE + R_DST};
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  logic [1:0]   age;  // edges since reset, saturates at 2

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1  <= '0;
      q   <= '0;
      age <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
      if (age != 2'd2) age <= age + 2'd1;
    end
  end

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2) |-> (q == $past(d, 2))); // R8
endmodule

// File: rtl/gpio_sc_reg.sv
module gpio_sc_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (set_en) q <= q | bits;
    else if (clr_en) q <= q & ~bits;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((q & $past(bits)) == $past(bits))); // R3
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> ((q & $past(bits)) == '0)); // R3
  AST_ZERO_BITS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> (((q ^ $past(q)) & ~$past(bits)) == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_en || clr_en) |=> $stable(q)); // R9
endmodule

// File: rtl/gpio_std_port.sv
module gpio_std_port
  import gpio_sc_pkg::*;
#(
  parameter int            W    = 8,
  parameter logic [AW-1:0] BASE = 8'h40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic [W-1:0]  wbits,
  input  logic [W-1:0]  pin_s,
  output logic [W-1:0]  out_q,
  output logic [W-1:0]  oe_q,
  output logic [DW-1:0] in_word,
  output logic [DW-1:0] ost_word,
  output logic [DW-1:0] dst_word
);
  localparam logic [AW-1:0] A_OSET = BASE + R_OSET;
  localparam logic [AW-1:0] A_OCLR = BASE + R_OCLR;
  localparam logic [AW-1:0] A_DSET = BASE + R_DSET;
  localparam logic [AW-1:0] A_DCLR = BASE + R_DCLR;

  logic st_oset, st_oclr, st_dset, st_dclr;
  assign st_oset = we && (addr == A_OSET);
  assign st_oclr = we && (addr == A_OCLR);
  assign st_dset = we && (addr == A_DSET);
  assign st_dclr = we && (addr == A_DCLR);

  gpio_sc_reg #(.W(W)) u_out (.clk(clk), .rst_n(rst_n), .set_en(st_oset),
    .clr_en(st_oclr), .bits(wbits), .q(out_q));
  gpio_sc_reg #(.W(W)) u_dir (.clk(clk), .rst_n(rst_n), .set_en(st_dset),
    .clr_en(st_dclr), .bits(wbits), .q(oe_q));

  assign in_word  = DW'(pin_s);
  assign ost_word = DW'(out_q);
  assign dst_word = DW'(oe_q);
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_sc_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] w_p3in,
  input  logic [DW-1:0] w_p3ost,
  input  logic [DW-1:0] w_d2st,
  input  logic [DW-1:0] w_p2in,
  input  logic [DW-1:0] w_p0in,
  input  logic [DW-1:0] w_p0ost,
  input  logic [DW-1:0] w_p0dst,
  input  logic [DW-1:0] w_p1in,
  input  logic [DW-1:0] w_p1ost,
  input  logic [DW-1:0] w_p1dst,
  output logic [DW-1:0] rdata
);
  always_comb begin
    case (addr)
      A_P3_IN:            rdata = w_p3in;
      A_P3_OST:           rdata = w_p3ost;
      A_D2_ST:            rdata = w_d2st;
      A_P2_IN:            rdata = w_p2in;
      A_P0_BASE + R_IN:   rdata = w_p0in;
      A_P0_BASE + R_OST:  rdata = w_p0ost;
      A_P0_BASE + R_DST:  rdata = w_p0dst;
      A_P1_BASE + R_IN:   rdata = w_p1in;
      A_P1_BASE + R_OST:  rdata = w_p1ost;
      A_P1_BASE + R_DST:  rdata = w_p1dst;
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
  import gpio_sc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [P0W-1:0]  p0_in,
  output logic [P0W-1:0]  p0_out,
  output logic [P0W-1:0]  p0_oe,
  input  logic [P1W-1:0]  p1_in,
  output logic [P1W-1:0]  p1_out,
  output logic [P1W-1:0]  p1_oe,
  input  logic [P2W-1:0]  p2_in,
  output logic [P2W-1:0]  p2_out,
  output logic [P2W-1:0]  p2_oe,
  input  logic [P3BW-1:0] p3io_in,
  output logic [P3BW-1:0] p3io_out,
  output logic [P3BW-1:0] p3io_oe,
  input  logic [P3IW-1:0] p3i_in,
  output logic [P3OW-1:0] p3o_out
);
  localparam int SO1 = P0W;
  localparam int SO2 = SO1 + P1W;
  localparam int SO3 = SO2 + P2W;
  localparam int SO4 = SO3 + P3BW;
  localparam int SW  = SO4 + P3IW;

  // synchronized inputs
  logic [SW-1:0] raw_in, syn_in;
  assign raw_in = {p3i_in, p3io_in, p2_in, p1_in, p0_in};
  gpio_sync2 #(.W(SW)) u_sync (.clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn_in));

  logic [P0W-1:0]  s_p0;
  logic [P1W-1:0]  s_p1;
  logic [P2W-1:0]  s_p2;
  logic [P3BW-1:0] s_p3b;
  logic [P3IW-1:0] s_p3i;
  assign s_p0  = syn_in[0 +: P0W];
  assign s_p1  = syn_in[SO1 +: P1W];
  assign s_p2  = syn_in[SO2 +: P2W];
  assign s_p3b = syn_in[SO3 +: P3BW];
  assign s_p3i = syn_in[SO4 +: P3IW];

  // write data bits 24 and 31 drive no state
  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[DW-1], bus_wdata[P3OW]};

  // regular ports 0 and 1
  logic [DW-1:0] w_p0in, w_p0ost, w_p0dst, w_p1in, w_p1ost, w_p1dst;

  gpio_std_port #(.W(P0W), .BASE(A_P0_BASE)) u_p0 (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wbits(bus_wdata[P0W-1:0]), .pin_s(s_p0), .out_q(p0_out), .oe_q(p0_oe),
    .in_word(w_p0in), .ost_word(w_p0ost), .dst_word(w_p0dst));

  gpio_std_port #(.W(P1W), .BASE(A_P1_BASE)) u_p1 (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wbits(bus_wdata[P1W-1:0]), .pin_s(s_p1), .out_q(p1_out), .oe_q(p1_oe),
    .in_word(w_p1in), .ost_word(w_p1ost), .dst_word(w_p1dst));

  // port 2 and port 3 strobes (port 3 bidir direction shares port 2's)
  logic st_d2_set, st_d2_clr, st_p2_oset, st_p2_oclr, st_p3_oset, st_p3_oclr;
  assign st_d2_set  = bus_we && (bus_addr == A_D2_SET);
  assign st_d2_clr  = bus_we && (bus_addr == A_D2_CLR);
  assign st_p2_oset = bus_we && (bus_addr == A_P2_OSET);
  assign st_p2_oclr = bus_we && (bus_addr == A_P2_OCLR);
  assign st_p3_oset = bus_we && (bus_addr == A_P3_OSET);
  assign st_p3_oclr = bus_we && (bus_addr == A_P3_OCLR);

  gpio_sc_reg #(.W(P2W)) u_d2 (.clk(clk), .rst_n(rst_n), .set_en(st_d2_set),
    .clr_en(st_d2_clr), .bits(bus_wdata[P2W-1:0]), .q(p2_oe));
  gpio_sc_reg #(.W(P3BW)) u_d3 (.clk(clk), .rst_n(rst_n), .set_en(st_d2_set),
    .clr_en(st_d2_clr), .bits(bus_wdata[P3B_LSB +: P3BW]), .q(p3io_oe));
  gpio_sc_reg #(.W(P2W)) u_o2 (.clk(clk), .rst_n(rst_n), .set_en(st_p2_oset),
    .clr_en(st_p2_oclr), .bits(bus_wdata[P2W-1:0]), .q(p2_out));
  gpio_sc_reg #(.W(P3BW)) u_o3b (.clk(clk), .rst_n(rst_n), .set_en(st_p3_oset),
    .clr_en(st_p3_oclr), .bits(bus_wdata[P3B_LSB +: P3BW]), .q(p3io_out));
  gpio_sc_reg #(.W(P3OW)) u_o3o (.clk(clk), .rst_n(rst_n), .set_en(st_p3_oset),
    .clr_en(st_p3_oclr), .bits(bus_wdata[P3OW-1:0]), .q(p3o_out));

  // readback words
  logic [DW-1:0] w_p3in, w_p3ost, w_d2st, w_p2in;
  assign w_p3in  = p3_in_word(s_p3b, s_p3i);
  assign w_p3ost = DW'(p3o_out) | (DW'(p3io_out) << P3B_LSB);
  assign w_d2st  = DW'(p2_oe)   | (DW'(p3io_oe)  << P3B_LSB);
  assign w_p2in  = DW'(s_p2);

  gpio_rd_mux u_rd (
    .addr(bus_addr), .w_p3in(w_p3in), .w_p3ost(w_p3ost), .w_d2st(w_d2st),
    .w_p2in(w_p2in), .w_p0in(w_p0in), .w_p0ost(w_p0ost), .w_p0dst(w_p0dst),
    .w_p1in(w_p1in), .w_p1ost(w_p1ost), .w_p1dst(w_p1dst), .rdata(bus_rdata));

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !is_readable(bus_addr) |-> (bus_rdata == '0)); // R9
  AST_P3_DIR_VIA_P2: assert property (@(posedge clk) disable iff (!rst_n)
    st_d2_set |=> ((p3io_oe & $past(bus_wdata[P3B_LSB +: P3BW]))
                   == $past(bus_wdata[P3B_LSB +: P3BW]))); // R5
  AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(p0_oe) && $stable(p1_oe) && $stable(p2_oe) &&
                 $stable(p3io_oe) && $stable(p3o_out))); // R9
endmodule

// File: tb/sim_gpio_setclr_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_setclr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  p0_in = '0, p0_out, p0_oe;
  logic [23:0] p1_in = '0, p1_out, p1_oe;
  logic [12:0] p2_in = '0, p2_out, p2_oe;
  logic [5:0]  p3io_in = '0, p3io_out, p3io_oe;
  logic [22:0] p3i_in = '0;
  logic [23:0] p3o_out;

  int nvec = 0, nfail = 0;
  bit done = 0;

  // bench model
  logic [7:0]  m_dir0, m_out0;
  logic [23:0] m_dir1, m_out1, m_o3o;
  logic [12:0] m_dir2, m_out2;
  logic [5:0]  m_dir3, m_o3b;

  always #5 clk = ~clk;

  gpio_setclr_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic mdl_reset();
    m_dir0 = '0; m_out0 = '0; m_dir1 = '0; m_out1 = '0; m_o3o = '0;
    m_dir2 = '0; m_out2 = '0; m_dir3 = '0; m_o3b = '0;
  endtask

  task automatic mdl_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h04: begin m_o3o |= d[23:0];  m_o3b |= d[30:25]; end
      8'h08: begin m_o3o &= ~d[23:0]; m_o3b &= ~d[30:25]; end
      8'h10: begin m_dir2 |= d[12:0];  m_dir3 |= d[30:25]; end
      8'h14: begin m_dir2 &= ~d[12:0]; m_dir3 &= ~d[30:25]; end
      8'h20: m_out2 |= d[12:0];
      8'h24: m_out2 &= ~d[12:0];
      8'h44: m_out0 |= d[7:0];
      8'h48: m_out0 &= ~d[7:0];
      8'h50: m_dir0 |= d[7:0];
      8'h54: m_dir0 &= ~d[7:0];
      8'h64: m_out1 |= d[23:0];
      8'h68: m_out1 &= ~d[23:0];
      8'h70: m_dir1 |= d[23:0];
      8'h74: m_dir1 &= ~d[23:0];
      default: ;
    endcase
  endtask

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: return {3'b0, p3i_in[22:19], p3io_in[5], p3i_in[18:10], p3io_in[4:0], p3i_in[9:0]};
      8'h0C: return {1'b0, m_o3b, 1'b0, m_o3o};
      8'h18: return {1'b0, m_dir3, 12'b0, m_dir2};
      8'h1C: return {19'b0, p2_in};
      8'h40: return {24'b0, p0_in};
      8'h4C: return {24'b0, m_out0};
      8'h58: return {24'b0, m_dir0};
      8'h60: return {8'b0, p1_in};
      8'h6C: return {8'b0, m_out1};
      8'h78: return {8'b0, m_dir1};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string req_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h1C, 8'h40, 8'h60: return "R7 input map";
      8'h0C: return "R6 port3 out state";
      8'h18: return "R5 dir2 state (R2 low bits)";
      8'h4C, 8'h6C: return "R4 out state";
      8'h58, 8'h78: return "R2 dir state";
      default: return "R9 unmapped read";
    endcase
  endfunction

  function automatic logic [7:0] addr_pick(input int unsigned i);
    case (i % 26)
      0: return 8'h04;  1: return 8'h08;  2: return 8'h10;  3: return 8'h14;
      4: return 8'h20;  5: return 8'h24;  6: return 8'h44;  7: return 8'h48;
      8: return 8'h50;  9: return 8'h54; 10: return 8'h64; 11: return 8'h68;
      12: return 8'h70; 13: return 8'h74; 14: return 8'h00; 15: return 8'h0C;
      16: return 8'h18; 17: return 8'h4C; 18: return 8'h58; 19: return 8'h2C;
      20: return 8'h30; 21: return 8'h3C; 22: return 8'h7C; 23: return 8'h80;
      24: return 8'h41; default: return 8'hFC;
    endcase
  endfunction

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.2;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_we = 1'b0;
    mdl_write(a, d);
  endtask

  task automatic check_all(input logic [7:0] extra);
    logic [31:0] v;
    logic [7:0] regs [10] = '{8'h00, 8'h0C, 8'h18, 8'h1C, 8'h40, 8'h4C, 8'h58, 8'h60, 8'h6C, 8'h78};
    chk("R4 p0_out", 32'(p0_out), 32'(m_out0));
    chk("R2 p0_oe", 32'(p0_oe), 32'(m_dir0));
    chk("R4 p1_out", 32'(p1_out), 32'(m_out1));
    chk("R2 p1_oe", 32'(p1_oe), 32'(m_dir1));
    chk("R4 p2_out", 32'(p2_out), 32'(m_out2));
    chk("R2 p2_oe", 32'(p2_oe), 32'(m_dir2));
    chk("R6 p3io_out", 32'(p3io_out), 32'(m_o3b));
    chk("R5 p3io_oe", 32'(p3io_oe), 32'(m_dir3));
    chk("R6 p3o_out", 32'(p3o_out), 32'(m_o3o));
    for (int i = 0; i < 10; i++) begin
      rd(regs[i], v);
      chk(req_of(regs[i]), v, exp_rd(regs[i]));
    end
    rd(extra, v);
    chk(req_of(extra), v, exp_rd(extra));
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] v;
    int unsigned r;
    mdl_reset();
    r = $urandom(32'h0C0FFEE5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state, during and after reset
    chk("R1 oe during reset", 32'({p0_oe, p1_oe}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all(8'h04);

    // R3 set then partial clear on port 0 outputs
    wr(8'h44, 32'h0000_00FF);
    wr(8'h48, 32'h0000_000F);
    @(negedge clk);
    rd(8'h4C, v); chk("R3 partial clear", v, 32'h0000_00F0);
    wr(8'h44, 32'h0000_0001);
    @(negedge clk);
    rd(8'h4C, v); chk("R3 zero bits hold", v, 32'h0000_00F1);

    // R5 port 3 direction through port 2 offsets, not onto p2_oe high bits
    wr(8'h10, 32'h7E00_0000);
    @(negedge clk);
    chk("R5 p3io_oe set", 32'(p3io_oe), 32'h3F);
    chk("R5 p2_oe untouched", 32'(p2_oe), 32'h0);
    wr(8'h14, 32'h0400_0000);
    @(negedge clk);
    chk("R5 p3io_oe clear bit 26", 32'(p3io_oe), 32'h3D);

    // R6 output-only vs bidir fields
    wr(8'h04, 32'h4080_0001);
    @(negedge clk);
    chk("R6 p3o_out", 32'(p3o_out), 32'h80_0001);
    chk("R6 p3io_out pin5", 32'(p3io_out), 32'h20);
    rd(8'h04, v); chk("R9 set offset reads zero", v, 32'h0);

    // R4 latch shows on pin even while input
    wr(8'h20, 32'h0000_1001);
    @(negedge clk);
    chk("R4 p2_out with oe low", 32'(p2_out), 32'h1001);

    // R8 synchronizer latency on port 0
    @(negedge clk);
    p0_in = 8'hA5;
    @(posedge clk); @(negedge clk);
    rd(8'h40, v); chk("R8 one edge not yet", v, 32'h0);
    @(posedge clk); @(negedge clk);
    rd(8'h40, v); chk("R8 two edges visible", v, 32'hA5);

    // R7 irregular port 3 input positions
    p3io_in = 6'h20; p3i_in = '0; settle(); settle();
    rd(8'h00, v); chk("R7 bidir pin5 at bit24", v, 32'h0100_0000);
    p3io_in = 6'h01; p3i_in = 23'h00_0400; settle(); settle();
    rd(8'h00, v); chk("R7 gpi10 bit15, bidir0 bit10", v, 32'h0000_8400);
    p3io_in = '0; p3i_in = 23'h08_0000; settle(); settle();
    rd(8'h00, v); chk("R7 gpi19 at bit25", v, 32'h0200_0000);

    // R9 writes of all ones to unmapped and read-only offsets
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h81, 32'hFFFF_FFFF);
    @(negedge clk);
    check_all(8'h2C);

    // random mix
    for (int it = 0; it < 600; it++) begin
      @(negedge clk);
      p0_in = 8'($urandom); p1_in = 24'($urandom); p2_in = 13'($urandom);
      p3io_in = 6'($urandom); p3i_in = 23'($urandom);
      wr(addr_pick($urandom), $urandom);
      settle();
      check_all(addr_pick(19 + ($urandom % 7)));
    end

    // reset again returns to reset state (R1)
    @(negedge clk);
    rst_n = 1'b0;
    mdl_reset();
    @(negedge clk);
    rst_n = 1'b1;
    p0_in = '0; p1_in = '0; p2_in = '0; p3io_in = '0; p3i_in = '0;
    settle(); settle();
    check_all(8'h08);
    chk("R1 after second reset", 32'({p3io_oe, p2_oe}), 32'h0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule